// File: doc/BRIEF.md
# Sliding Window Address Translator

This block sits on the device side of a 256-byte memory BAR and turns small host offsets into accesses on a 32-bit internal bus. The BAR is split into four regions. Two fixed windows sit at the bottom. A hole in the middle returns a copy of configuration bytes. A large window at the top can be moved anywhere in the internal space at run time. Each window has its own base register. The internal address is that base plus the distance of the offset from the start of the window.

Accesses are 8, 16 or 32 bits wide and may start at any offset. The region is chosen from the starting offset alone. The translation is combinational, so a window access reaches the internal bus in the same cycle as the host strobe. Read data returns in that same cycle, whether it comes from internal memory or from the configuration copy. Base registers are loaded through a separate configuration write port. The base of the large window is always forced to a multiple of its own size.

Top module: `swin_xlate`

## Requirements
- R1: Offsets 0x00 to 0x57 select the low window: internal address = low base + offset.
- R2: Offsets 0x58 to 0x5F select the small window: internal address = small base + (offset − 0x58).
- R3: Offsets 0x80 to 0xFF select the large window: internal address = large base + (offset − 0x80).
- R4: A read at offsets 0x60 to 0x7F raises no internal request. It returns copy bytes taken little-endian from index (offset − 0x60), where copy byte k is `cfg_mirror[8k+7:8k]`. The result is masked to the access size (size 0 = 8 bits, 1 = 16 bits, 2 = 32 bits), and bytes past index 31 read as zero.
- R5: A write at offsets 0x60 to 0x7F is ignored: no internal request and no change to any base.
- R6: A write to the large window's base clears the low 7 bits, which keeps the base aligned to the 128-byte window size.
- R7: Base writes use `cfg_sel` 0 = low window, 1 = large window, 2 = small window, and take effect from the next cycle. A value of 3 changes nothing.
- R8: After reset all three bases are zero.
- R9: For a window access, `ib_req` is high in the same cycle as the strobe. `ib_we`, `ib_size` and `ib_wdata` follow the host, and `acc_rdata` equals `ib_rdata`.
- R10: The region is decoded from the starting offset. A wide access that crosses a region edge goes entirely to the region where it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rd | input | 1 | Host read strobe |
| acc_wr | input | 1 | Host write strobe |
| acc_off | input | 8 | BAR byte offset |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword |
| acc_wdata | input | 32 | Host write data |
| acc_rdata | output | 32 | Host read data |
| cfg_we | input | 1 | Base register write strobe |
| cfg_sel | input | 2 | Base register select |
| cfg_wdata | input | 32 | Base register value |
| cfg_mirror | input | 256 | Configuration bytes 0x60..0x7F, byte k at bits 8k+7:8k |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus write |
| ib_addr | output | 32 | Translated internal address |
| ib_size | output | 2 | Internal access size |
| ib_wdata | output | 32 | Internal write data |
| ib_rdata | input | 32 | Internal read data |

## Verification
The assertions take three things for granted about the inputs. A host read and a host write are never strobed together. The access size is never 3. A base write and an access in the same cycle are judged against the base value from before that write. The stimulus drives one strobe at a time and uses only sizes 0 to 2. Each base write is issued alone, and the accesses that depend on it come in later cycles.

// File: rtl/swin_xlate.sv
module swin_xlate #(
  parameter int IAW    = 32,
  parameter int WA_LEN = 88,
  parameter int WC_LEN = 8,
  parameter int MR_LEN = 32,
  parameter int B_LOG2 = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_rd,
  input  logic                acc_wr,
  input  logic [7:0]          acc_off,
  input  logic [1:0]          acc_size,
  input  logic [31:0]         acc_wdata,
  output logic [31:0]         acc_rdata,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [IAW-1:0]      cfg_wdata,
  input  logic [MR_LEN*8-1:0] cfg_mirror,
  output logic                ib_req,
  output logic                ib_we,
  output logic [IAW-1:0]      ib_addr,
  output logic [1:0]          ib_size,
  output logic [31:0]         ib_wdata,
  input  logic [31:0]         ib_rdata
);
  localparam int BAR_AW = 8;
  localparam logic [BAR_AW-1:0] C_OFF = BAR_AW'(WA_LEN);
  localparam logic [BAR_AW-1:0] M_OFF = BAR_AW'(WA_LEN + WC_LEN);
  localparam logic [BAR_AW-1:0] B_OFF = BAR_AW'(WA_LEN + WC_LEN + MR_LEN);
  localparam logic [IAW-1:0] B_MASK = IAW'((64'd1 << B_LOG2) - 64'd1);

  logic [IAW-1:0] base_a, base_b, base_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a <= '0;
      base_b <= '0;
      base_c <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: base_a <= cfg_wdata;
        2'd1: base_b <= cfg_wdata & ~B_MASK;
        2'd2: base_c <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic in_a, in_c, in_m;
  assign in_a = acc_off < C_OFF;
  assign in_c = !in_a && (acc_off < M_OFF);
  assign in_m = !in_a && !in_c && (acc_off < B_OFF);

  logic [BAR_AW-1:0] rel;
  logic [IAW-1:0]    win_base;
  always_comb begin
    if (in_a) begin
      rel = acc_off;
      win_base = base_a;
    end else if (in_c) begin
      rel = acc_off - C_OFF;
      win_base = base_c;
    end else begin
      rel = acc_off - B_OFF;
      win_base = base_b;
    end
  end

  assign ib_req   = (acc_rd || acc_wr) && !in_m;
  assign ib_we    = acc_wr && !in_m;
  assign ib_addr  = win_base + IAW'(rel);
  assign ib_size  = acc_size;
  assign ib_wdata = acc_wdata;

  logic [BAR_AW-1:0]     m_idx;
  logic [MR_LEN*8-1:0]   m_shift;
  logic [31:0]           m_word;
  assign m_idx   = acc_off - M_OFF;
  assign m_shift = cfg_mirror >> {m_idx, 3'b000};

  always_comb begin
    case (acc_size)
      2'd0:    m_word = {24'd0, m_shift[7:0]};
      2'd1:    m_word = {16'd0, m_shift[15:0]};
      default: m_word = m_shift[31:0];
    endcase
  end

  assign acc_rdata = in_m ? m_word : ib_rdata;
endmodule

module swin_xlate_chk #(
  parameter int IAW    = 32,
  parameter int WA_LEN = 88,
  parameter int WC_LEN = 8,
  parameter int MR_LEN = 32,
  parameter int B_LOG2 = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_rd,
  input logic           acc_wr,
  input logic [7:0]     acc_off,
  input logic [1:0]     acc_size,
  input logic           cfg_we,
  input logic [1:0]     cfg_sel,
  input logic [IAW-1:0] cfg_wdata,
  input logic           ib_req,
  input logic           ib_we,
  input logic [IAW-1:0] ib_addr,
  input logic [1:0]     ib_size
);
  localparam logic [7:0] M_OFF = 8'(WA_LEN + WC_LEN);
  localparam logic [7:0] B_OFF = 8'(WA_LEN + WC_LEN + MR_LEN);
  localparam logic [IAW-1:0] B_MASK = IAW'((64'd1 << B_LOG2) - 64'd1);

  logic hole;
  assign hole = (acc_off >= M_OFF) && (acc_off < B_OFF);

  a_r4_hole_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    hole |-> !ib_req);

  a_r5_hole_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hole && acc_wr) |-> !ib_we);

  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> (ib_size == acc_size && ib_we == acc_wr));

  a_r6_b_align: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we && cfg_sel == 2'd1) && acc_rd && acc_off == B_OFF)
      |-> ib_addr == ($past(cfg_wdata) & ~B_MASK));

  a_r7_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_we) && acc_rd && $past(acc_rd)
      && acc_off == 8'd0 && $past(acc_off) == 8'd0) |-> $stable(ib_addr));

  a_r8_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && acc_rd && acc_off == 8'd0) |-> ib_addr == '0);
endmodule

bind swin_xlate swin_xlate_chk #(
  .IAW(IAW), .WA_LEN(WA_LEN), .WC_LEN(WC_LEN), .MR_LEN(MR_LEN), .B_LOG2(B_LOG2)
) u_chk (.*);

// File: tb/sim_swin_xlate.sv
`timescale 1ns/1ps
module sim_swin_xlate;
  logic clk = 0, rst_n = 0;
  logic acc_rd = 0, acc_wr = 0;
  logic [7:0] acc_off = 0;
  logic [1:0] acc_size = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [255:0] cfg_mirror;
  logic ib_req, ib_we;
  logic [31:0] ib_addr, ib_wdata;
  logic [1:0] ib_size;
  logic [31:0] ib_rdata = 32'h5566_7788;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swin_xlate u0 (.*);

  always_comb for (int k = 0; k < 32; k++) cfg_mirror[8*k +: 8] = 8'hA0 + 8'(k);

  typedef struct packed {
    logic [7:0]  off;
    logic [1:0]  sz;
    logic        wr;
    logic        req;
    logic [31:0] addr;
    logic [3:0]  tag;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'h00, 2'd2, 1'b0, 1'b1, 32'h1000_0000, 4'd1},  // R1
    '{8'h57, 2'd0, 1'b1, 1'b1, 32'h1000_0057, 4'd1},  // R1
    '{8'h56, 2'd2, 1'b0, 1'b1, 32'h1000_0056, 4'd10}, // R10
    '{8'h58, 2'd1, 1'b0, 1'b1, 32'h2000_0040, 4'd2},  // R2
    '{8'h5F, 2'd0, 1'b1, 1'b1, 32'h2000_0047, 4'd2},  // R2
    '{8'h5E, 2'd2, 1'b0, 1'b1, 32'h2000_0046, 4'd10}, // R10
    '{8'h80, 2'd2, 1'b0, 1'b1, 32'hABCD_1280, 4'd3},  // R3
    '{8'hFF, 2'd0, 1'b1, 1'b1, 32'hABCD_12FF, 4'd3},  // R3
    '{8'h60, 2'd2, 1'b0, 1'b0, 32'h0,         4'd4},  // R4
    '{8'h7F, 2'd0, 1'b1, 1'b0, 32'h0,         4'd5}   // R5
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input [7:0] off, input [1:0] sz, input bit wr);
    @(posedge clk); #1;
    acc_off = off; acc_size = sz; acc_rd = !wr; acc_wr = wr; acc_wdata = 32'hCAFE_0000 | 32'(off);
    @(negedge clk);
  endtask

  task automatic idle;
    @(posedge clk); #1; acc_rd = 0; acc_wr = 0;
  endtask

  task automatic cfg(input [1:0] sel, input [31:0] v);
    @(posedge clk); #1; cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R8: bases zero after reset
    acc(8'h10, 2'd0, 0); check("R8 low", ib_addr, 32'h10);
    acc(8'h5A, 2'd0, 0); check("R8 small", ib_addr, 32'h2);
    acc(8'h81, 2'd0, 0); check("R8 large", ib_addr, 32'h1);
    idle();
    cfg(2'd0, 32'h1000_0000);
    cfg(2'd2, 32'h2000_0040);
    cfg(2'd1, 32'hABCD_12FF); // R6: low bits dropped
    foreach (VECS[i]) begin
      acc(VECS[i].off, VECS[i].sz, VECS[i].wr);
      check($sformatf("R%0d req @%h", VECS[i].tag, VECS[i].off), 32'(ib_req), 32'(VECS[i].req));
      if (VECS[i].req) begin
        check($sformatf("R%0d addr @%h", VECS[i].tag, VECS[i].off), ib_addr, VECS[i].addr);
        check("R9 we", 32'(ib_we), 32'(VECS[i].wr));
        check("R9 size", 32'(ib_size), 32'(VECS[i].sz));
      end
    end
    // R9: window read data and write data pass through
    acc(8'h20, 2'd2, 0); check("R9 rdata", acc_rdata, 32'h5566_7788);
    acc(8'h90, 2'd2, 1); check("R9 wdata", ib_wdata, 32'hCAFE_0090);
    // R4: mirror reads
    acc(8'h60, 2'd2, 0); check("R4 dword", acc_rdata, 32'hA3A2_A1A0);
    acc(8'h65, 2'd0, 0); check("R4 byte", acc_rdata, 32'h0000_00A5);
    acc(8'h7E, 2'd1, 0); check("R4 word", acc_rdata, 32'h0000_BFBE);
    acc(8'h7E, 2'd2, 0); check("R4 past end", acc_rdata, 32'h0000_BFBE);
    acc(8'h7F, 2'd0, 0); check("R4 no req", 32'(ib_req), 0);
    // R5: mirror write ignored, bases unchanged
    acc(8'h70, 2'd2, 1); check("R5 no req", 32'(ib_req), 0);
    check("R5 no we", 32'(ib_we), 0);
    acc(8'h70, 2'd2, 0); check("R5 mirror", acc_rdata, 32'hB3B2_B1B0);
    acc(8'h04, 2'd0, 0); check("R5 low base", ib_addr, 32'h1000_0004);
    // R7: select 3 writes nothing
    idle();
    cfg(2'd3, 32'hFFFF_FFFF);
    acc(8'h00, 2'd0, 0); check("R7 low", ib_addr, 32'h1000_0000);
    acc(8'h58, 2'd0, 0); check("R7 small", ib_addr, 32'h2000_0040);
    acc(8'h80, 2'd0, 0); check("R7 large", ib_addr, 32'hABCD_1280);
    // R6: second alignment pattern, R7 next-cycle effect
    idle();
    cfg(2'd1, 32'h0000_007F);
    acc(8'hC3, 2'd0, 0); check("R6 align", ib_addr, 32'h0000_0043);
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule